// File: doc/BRIEF.md
# MSI Request Edge-Trigger Bridge

This block connects a valid/ready stream of interrupt requests, normally the read side of a clock-crossing queue, to a configuration interrupt port of a PCIe endpoint. That port starts a message-signalled interrupt only on a rising edge of its request strobe. Every stream entry that the bridge accepts becomes exactly one launched request. The 32-bit interrupt vector is captured at launch and held until the endpoint answers with a sent or fail pulse. A sent pulse pops the stream entry. A fail pulse leaves the entry at the head of the stream, and the bridge launches it again.

The bridge keeps a two-bit history of a request qualifier. The qualifier is the stream valid, gated by the controller's armed condition and forced low in any cycle that carries a sent or fail pulse. A launch is taken when the history reads binary 01. A queue with several pending entries keeps valid high without a break. Because the response cycle always shifts a zero into the history, each entry still produces a fresh edge and the bridge cannot stall.

The controller is a three-state machine:
- **IDLE**: armed, waiting for an edge.
- **WAIT**: one request outstanding.
- **GAP**: a response has arrived, but the minimum launch spacing has not yet elapsed.

The transitions are:
- **IDLE→WAIT** on a launch.
- **WAIT→IDLE** on a response once the spacing has elapsed.
- **WAIT→GAP** on a response while the spacing is still running.
- **GAP→IDLE** when the spacing expires.

A saturating counter of fail responses is provided for debug.

Top module: `msi_edge_bridge`

## Requirements
- R1: After reset, `irq_req` is 0, `src_ready` is 0 and `fail_total` is 0.
- R2: With the bridge idle, the spacing elapsed and `src_valid` rising, `irq_req` rises two clock cycles after the cycle in which `src_valid` is first high. At that point `irq_vector` equals `src_vector`.
- R3: Only one request is outstanding at a time. `irq_req` stays high until a cycle with `irq_sent` or `irq_fail`, it is low in the following cycle, and it never rises again before such a response.
- R4: `src_ready` is high only in a cycle where `irq_sent` is high while `irq_req` is high, and each such cycle consumes exactly one stream entry.
- R5: A fail response leaves `src_ready` low, and the next launch carries the same vector again.
- R6: With eight entries queued and `src_valid` held high throughout, every vector is delivered by a sent response exactly once, in queue order, with no stall. This holds even when some responses are fails.
- R7: `irq_vector` does not change while `irq_req` is high.
- R8: Consecutive rising edges of `irq_req` are at least `MIN_GAP` clock cycles apart (bench instance: 10). A value of 0 or 1 disables the limit.
- R9: `fail_total` counts fail responses to outstanding requests and saturates at 2^`FAIL_CNT_W`-1 (bench instance: 7).
- R10: A sent or fail pulse while no request is outstanding is ignored. `src_ready` stays 0, `fail_total` is unchanged and no request is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-domain clock |
| rst | input | 1 | Synchronous active-high user-domain reset |
| src_valid | input | 1 | Stream entry available at the head |
| src_ready | output | 1 | Pops the head entry (sent response) |
| src_vector | input | VEC_W | Interrupt vector of the head entry |
| irq_req | output | 1 | Request strobe to the endpoint; a rising edge launches |
| irq_vector | output | VEC_W | Vector held for the endpoint during a request |
| irq_sent | input | 1 | Endpoint reports the interrupt was sent |
| irq_fail | input | 1 | Endpoint reports the interrupt failed |
| fail_total | output | FAIL_CNT_W | Saturating count of fail responses |

## Verification
A history register that fails to re-arm shows up at the ports as an `irq_req` that never rises again while `src_valid` stays high. The scoreboard flags this once the drain timeout of a few hundred cycles expires. A controller that loses track of the outstanding request shows either a second `irq_req` rise before any response or an `irq_req` still high in the cycle after a response, which is caught within one cycle. A wrong pop or a wrong vector latch shows at the next sent response as a mismatch against the expected queue order. A retry that carries a changed vector is caught at the following rise.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GAP  = 2'd2
    } bridge_state_t;

endpackage

// File: rtl/msi_edge_hist.sv
module msi_edge_hist (
    input  logic clk,
    input  logic rst,
    input  logic qual_in,
    input  logic resp_in,
    output logic edge_seen
);

    logic [1:0] hist_q;
    logic       masked_qual;

    // A response cycle always shifts in a zero, re-arming the edge.
    assign masked_qual = qual_in & ~resp_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 2'b00;
        end else begin
            hist_q <= {hist_q[0], masked_qual};
        end
    end

    assign edge_seen = (hist_q == 2'b01);

    p_rearm_on_resp_r6: assert property (@(posedge clk) disable iff (rst)
        resp_in |=> !hist_q[0]);

endmodule

// File: rtl/msi_launch_spacer.sv
module msi_launch_spacer #(
    parameter int MIN_GAP = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic gap_ok
);

    generate
        if (MIN_GAP <= 1) begin : g_nolimit
            logic unused_spacer_pins;
            assign unused_spacer_pins = clk ^ rst ^ launch;
            assign gap_ok = 1'b1;
        end else begin : g_limit
            localparam int GW = $clog2(MIN_GAP + 1);
            localparam logic [GW-1:0] LIMIT = GW'(MIN_GAP - 1);
            logic [GW-1:0] since_q;

            // Cycles since the last launch, saturating at LIMIT.
            always_ff @(posedge clk) begin
                if (rst) begin
                    since_q <= LIMIT;
                end else if (launch) begin
                    since_q <= '0;
                end else if (since_q != LIMIT) begin
                    since_q <= since_q + 1'b1;
                end
            end

            assign gap_ok = (since_q == LIMIT);

            p_launch_spacing_r8: assert property (@(posedge clk) disable iff (rst)
                launch |=> !gap_ok);
        end
    endgenerate

endmodule

// File: rtl/msi_fail_counter.sv
module msi_fail_counter #(
    parameter int FAIL_CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bump,
    output logic [FAIL_CNT_W-1:0] count
);

    localparam logic [FAIL_CNT_W-1:0] CNT_MAX = '1;

    logic [FAIL_CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (bump && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    p_fail_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    p_fail_step_r9: assert property (@(posedge clk) disable iff (rst)
        (bump && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
    import msi_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    input  logic src_valid,
    input  logic gap_ok,
    input  logic sent,
    input  logic fail,
    output logic armed,
    output logic launch,
    output logic outstanding,
    output logic pop,
    output logic fail_bump
);

    bridge_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_seen && src_valid) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sent || fail) begin
                    state_d = gap_ok ? ST_IDLE : ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_ok) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        armed       = 1'b0;
        launch      = 1'b0;
        outstanding = 1'b0;
        pop         = 1'b0;
        fail_bump   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                armed  = gap_ok;
                launch = edge_seen && src_valid;
            end
            ST_WAIT: begin
                outstanding = 1'b1;
                pop         = sent;
                fail_bump   = fail;
            end
            ST_GAP: begin
                armed = 1'b0;
            end
            default: begin
                armed = 1'b0;
            end
        endcase
    end

    p_gap_waits_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP && !gap_ok) |=> (state_q == ST_GAP));

endmodule

// File: rtl/msi_edge_bridge.sv
module msi_edge_bridge #(
    parameter int VEC_W      = 32,
    parameter int MIN_GAP    = 50,
    parameter int FAIL_CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  src_valid,
    output logic                  src_ready,
    input  logic [VEC_W-1:0]      src_vector,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vector,
    input  logic                  irq_sent,
    input  logic                  irq_fail,
    output logic [FAIL_CNT_W-1:0] fail_total
);

    logic             armed;
    logic             edge_seen;
    logic             launch;
    logic             outstanding;
    logic             pop;
    logic             fail_bump;
    logic             gap_ok;
    logic             resp_any;
    logic [VEC_W-1:0] vec_q;

    assign resp_any = irq_sent | irq_fail;

    msi_edge_hist u_hist (
        .clk       (clk),
        .rst       (rst),
        .qual_in   (src_valid & armed),
        .resp_in   (resp_any),
        .edge_seen (edge_seen)
    );

    msi_launch_spacer #(.MIN_GAP(MIN_GAP)) u_spacer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .gap_ok (gap_ok)
    );

    msi_req_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .edge_seen   (edge_seen),
        .src_valid   (src_valid),
        .gap_ok      (gap_ok),
        .sent        (irq_sent),
        .fail        (irq_fail),
        .armed       (armed),
        .launch      (launch),
        .outstanding (outstanding),
        .pop         (pop),
        .fail_bump   (fail_bump)
    );

    msi_fail_counter #(.FAIL_CNT_W(FAIL_CNT_W)) u_fails (
        .clk   (clk),
        .rst   (rst),
        .bump  (fail_bump),
        .count (fail_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (launch) begin
            vec_q <= src_vector;
        end
    end

    assign irq_req    = outstanding;
    assign irq_vector = vec_q;
    assign src_ready  = pop;

    p_ready_needs_sent_r4: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> (irq_sent && irq_req));

    p_req_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_req && resp_any) |=> !irq_req);

    p_req_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !resp_any) |=> irq_req);

    p_no_launch_busy_r3: assert property (@(posedge clk) disable iff (rst)
        launch |-> !irq_req);

    p_vec_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !resp_any) |=> $stable(irq_vector));

    p_fail_no_pop_r5: assert property (@(posedge clk) disable iff (rst)
        irq_fail |-> !src_ready);

    p_stray_resp_r10: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && resp_any) |=> ($stable(fail_total) && !irq_req));

endmodule

// File: tb/msi_edge_bridge_tb.sv
module msi_edge_bridge_tb_top;

    localparam int VEC_W   = 32;
    localparam int GAP     = 10;
    localparam int FCW     = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [VEC_W-1:0] s_vector = '0;
    logic             irq_req;
    logic [VEC_W-1:0] irq_vector;
    logic             m_sent = 1'b0, m_fail = 1'b0;
    logic             x_sent = 1'b0, x_fail = 1'b0;
    logic [FCW-1:0]   fail_total;

    always #10 clk = ~clk;

    msi_edge_bridge #(.VEC_W(VEC_W), .MIN_GAP(GAP), .FAIL_CNT_W(FCW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_valid  (s_valid),
        .src_ready  (s_ready),
        .src_vector (s_vector),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .irq_sent   (m_sent | x_sent),
        .irq_fail   (m_fail | x_fail),
        .fail_total (fail_total)
    );

    int unsigned      n_checks = 0;
    int unsigned      n_fails  = 0;
    logic [VEC_W-1:0] stream_q[$];
    logic [VEC_W-1:0] exp_q[$];
    int               cyc = 0;
    int               rise_cnt = 0;
    int               last_rise = 0;
    int               delivered = 0;
    int               fail_pct = 0;
    bit               force_fail = 0;
    bit               done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_vec(input logic [VEC_W-1:0] v);
        stream_q.push_back(v);
        exp_q.push_back(v);
    endtask

    // Endpoint model, stream source and scoreboard monitor.
    initial begin
        bit               req_prev = 0, pending = 0, have_rise = 0;
        bit               last_fail = 0, pop_pend = 0, resp_was;
        int               delay = 0;
        logic [VEC_W-1:0] last_vec = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                req_prev = 0;
                continue;
            end
            if (pop_pend) begin
                void'(stream_q.pop_front());
                pop_pend = 0;
            end
            resp_was = m_sent | m_fail;
            m_sent = 0;
            m_fail = 0;
            if (resp_was)
                chk(irq_req == 1'b0, "R3 req low after response", irq_req, 0);
            if (irq_req && !req_prev) begin
                chk(!pending, "R3 rise while outstanding", pending, 0);
                if (have_rise)
                    chk(cyc - last_rise >= GAP, "R8 launch spacing", cyc - last_rise, GAP);
                if (last_fail)
                    chk(irq_vector == last_vec, "R5 retry vector", irq_vector, last_vec);
                pending   = 1;
                delay     = $urandom_range(20, 1);
                last_vec  = irq_vector;
                rise_cnt++;
                last_rise = cyc;
                have_rise = 1;
            end else if (pending) begin
                if (irq_vector != last_vec)
                    chk(0, "R7 vector stable", irq_vector, last_vec);
                delay--;
                if (delay == 0) begin
                    if (force_fail || $urandom_range(99, 0) < fail_pct) m_fail = 1;
                    else m_sent = 1;
                    pending = 0;
                end
            end
            req_prev = irq_req;
            s_valid  = (stream_q.size() != 0);
            s_vector = (stream_q.size() != 0) ? stream_q[0] : '0;
            #1;
            if (m_sent) begin
                chk(s_ready == 1'b1, "R4 ready on sent", s_ready, 1);
                pop_pend  = s_ready;
                last_fail = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected delivery", irq_vector, 0);
                end else begin
                    chk(irq_vector == exp_q[0], "R6 delivery order", irq_vector, exp_q[0]);
                    void'(exp_q.pop_front());
                    delivered++;
                end
            end
            if (m_fail) begin
                chk(s_ready == 1'b0, "R5 no ready on fail", s_ready, 0);
                last_fail = 1;
            end
        end
    end

    task automatic drain(input int limit, input string req);
        int n = 0;
        while ((exp_q.size() != 0 || irq_req) && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        int c0, r0, d0;
        logic [FCW-1:0] f0;
        repeat (5) @(negedge clk);
        // R1: reset state, sampled while reset is held
        chk(irq_req == 0, "R1 req at reset", irq_req, 0);
        chk(s_ready == 0, "R1 ready at reset", s_ready, 0);
        chk(fail_total == 0, "R1 fail_total at reset", fail_total, 0);
        rst = 0;
        repeat (20) @(negedge clk);
        chk(irq_req == 0, "R1 req idle after reset", irq_req, 0);

        // R2: launch latency and vector capture
        @(posedge clk); #2;
        r0 = rise_cnt;
        c0 = cyc + 1;
        push_vec(32'hA5A5_0001);
        repeat (4) @(negedge clk);
        #3;
        chk(rise_cnt == r0 + 1, "R2 launched", rise_cnt, r0 + 1);
        chk(last_rise == c0 + 2, "R2 launch latency", last_rise, c0 + 2);
        chk(irq_vector == 32'hA5A5_0001, "R2 vector", irq_vector, 32'hA5A5_0001);
        drain(200, "R2 drain");
        repeat (20) @(negedge clk);

        // R10: stray responses while idle
        f0 = fail_total;
        r0 = rise_cnt;
        #2; x_sent = 1;
        #1; chk(s_ready == 0, "R10 stray sent no ready", s_ready, 0);
        @(negedge clk); #2; x_sent = 0; x_fail = 1;
        #1; chk(s_ready == 0, "R10 stray fail no ready", s_ready, 0);
        @(negedge clk); #2; x_fail = 0;
        repeat (3) @(negedge clk);
        #3;
        chk(fail_total == f0, "R10 fail_total unchanged", fail_total, f0);
        chk(rise_cnt == r0 && irq_req == 0, "R10 no launch", rise_cnt, r0);

        // R5 / R9: repeated fails retry the same entry, counter saturates
        force_fail = 1;
        r0 = rise_cnt;
        d0 = delivered;
        @(posedge clk); #2;
        push_vec(32'h0BAD_F00D);
        while (rise_cnt < r0 + 10) @(negedge clk);
        while (irq_req) @(negedge clk);
        repeat (2) @(negedge clk);
        #3;
        chk(fail_total == 3'd7, "R9 saturated", fail_total, 7);
        chk(stream_q.size() == 1, "R5 entry kept at head", stream_q.size(), 1);
        chk(delivered == d0, "R5 nothing delivered", delivered, d0);
        force_fail = 0;
        drain(300, "R5 retry drains");
        chk(fail_total == 3'd7, "R9 held at max", fail_total, 7);

        // R6: eight queued entries, valid held high, random fails
        fail_pct = 25;
        d0 = delivered;
        @(posedge clk); #2;
        for (int i = 0; i < 8; i++) push_vec(32'h1000_0000 + 32'(i * 17));
        drain(2000, "R6 no stall with fails");
        chk(delivered == d0 + 8, "R6 count with fails", delivered, d0 + 8);

        // R6 / R8: eight more, all sent
        fail_pct = 0;
        d0 = delivered;
        @(posedge clk); #2;
        for (int i = 0; i < 8; i++) push_vec(32'hC0DE_0000 ^ 32'(i << 4));
        drain(1000, "R6 no stall");
        chk(delivered == d0 + 8, "R6 count", delivered, d0 + 8);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule